// File: doc/BRIEF.md
# Successive-Integration Converter Sequencer

This block is the digital controller of an integrating analog-to-digital converter that refines its reading by amplifying the integrator residue. A free-running cycle counter paces a fixed-length conversion cycle. Within it, a phase machine drives one-hot switch controls for the analog section. First comes a signal integrate phase. Then come three de-integrate stages against the reference, separated by rest phases in which the analog side amplifies the leftover residue by ten. The machine reads one comparator bit that reports the integrator's polarity.

Each de-integrate clock moves a signed results accumulator by a weight that falls tenfold from stage to stage. Offsets in the buffer, integrator and comparator are removed in the digital domain. After the measurement pass, the same sequence runs again with the inputs shorted, and its counts enter the accumulator with the opposite sign. At the end of every cycle the accumulator is scaled to display resolution and latched, and a one-clock done pulse marks the update. A range input selects a short or a long integrate. This rescales the reading tenfold without touching the reference.

Top module: `sint_adc_seq`

## Requirements
- R1: While rst_n is low, sw_ctrl is 6'b000001, result is 0 and done is 0.
- R2: Exactly one bit of sw_ctrl is high on every clock. The bit meanings are: bit0 signal integrate, bit1 zero integrate with the inputs shorted, bit2 de-integrate driving the integrator up, bit3 de-integrate driving it down, bit4 rest with residue gain of ten, bit5 hold.
- R3: Both integrate phases of a cycle last INT_SHORT clocks when rng_hi was 1 at the start of the cycle, and INT_LONG clocks when it was 0. rng_hi is sampled only in reset and on the edge that starts a cycle.
- R4: On the edge that enters a de-integrate stage, the stage takes bit3 if cmp_pos is 1 on that edge, and bit2 otherwise.
- R5: A de-integrate stage ends on the first edge on which cmp_pos differs from the level that chose its direction. If that does not happen first, stage one ends after DE1_MAX clocks and stages two and three end after DE_FINE_MAX clocks.
- R6: A rest phase of REST_LEN clocks separates stage one from stage two and stage two from stage three.
- R7: Each clock of stage one, two or three moves the accumulator by 100, 10 or 1 fine units. The move is positive for bit3 in the measurement pass. result is the accumulator divided by ten and truncated toward zero.
- R8: After the third measurement stage, a zero pass runs. It uses bit1 in place of bit0, with the same integrate length and the same three stages, and its counts enter with the opposite sign. The block then holds (bit5) until the cycle ends.
- R9: A cycle lasts exactly CYCLE_LEN clocks on both ranges. done is high for one clock per cycle, and result is updated on the same edge that raises done.
- R10: result changes only on an edge that raises done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rng_hi | input | 1 | 1 selects short integrate (coarse range), 0 long integrate |
| cmp_pos | input | 1 | Comparator: 1 when the integrator is above its start level |
| sw_ctrl | output | 6 | One-hot analog switch controls (see R2) |
| result | output | RES_W | Signed reading in display counts |
| done | output | 1 | One-clock pulse when result is updated |

## Verification
The edge that ends a cycle does three things at once: it latches the result, restarts the integrate phase and samples the range input. A range change can therefore land inside a running cycle or right at its boundary. The bench flips rng_hi while a long integrate is under way. It then checks that both integrate phases of that cycle keep the old length, and that the next cycle uses the new one. A second collision occurs in a de-integrate stage whose comparator never flips, so the timeout and the count step fall on the same clock. An overdriven input provokes this case, and both the stage length and the exact latched reading are checked.

// File: rtl/sint_adc_seq.sv
module sint_adc_seq #(
  parameter int INT_SHORT   = 1000,
  parameter int INT_LONG    = 10000,
  parameter int DE1_MAX     = 4000,
  parameter int DE_FINE_MAX = 20,
  parameter int REST_LEN    = 100,
  parameter int CYCLE_LEN   = 30000,
  parameter int RES_W       = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rng_hi,
  input  logic                    cmp_pos,
  output logic [5:0]              sw_ctrl,
  output logic signed [RES_W-1:0] result,
  output logic                    done
);
  localparam int M1    = (INT_LONG > INT_SHORT) ? INT_LONG : INT_SHORT;
  localparam int M2    = (DE1_MAX > DE_FINE_MAX) ? DE1_MAX : DE_FINE_MAX;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int LMAX  = (M3 > REST_LEN) ? M3 : REST_LEN;
  localparam int PH_W  = $clog2(LMAX + 1);
  localparam int CY_W  = $clog2(CYCLE_LEN);
  localparam int ACC_W = RES_W + 4;
  localparam logic signed [ACC_W-1:0] W_S1 = 100;
  localparam logic signed [ACC_W-1:0] W_S2 = 10;
  localparam logic signed [ACC_W-1:0] W_S3 = 1;
  localparam logic signed [ACC_W-1:0] TEN  = 10;

  typedef enum logic [1:0] {P_INT, P_DE, P_REST, P_HOLD} phase_t;

  phase_t                   ph;
  logic [1:0]               stg;
  logic                     zpass, dir, rng_q;
  logic [PH_W-1:0]          ph_cnt;
  logic [CY_W-1:0]          cy_cnt;
  logic signed [ACC_W-1:0]  acc;

  wire [PH_W-1:0] int_last = rng_q ? PH_W'(INT_SHORT - 1) : PH_W'(INT_LONG - 1);
  wire [PH_W-1:0] de_last  = (stg == 2'd0) ? PH_W'(DE1_MAX - 1) : PH_W'(DE_FINE_MAX - 1);
  wire            cyc_end  = (cy_cnt == CY_W'(CYCLE_LEN - 1));
  wire            de_stop  = (cmp_pos != dir) || (ph_cnt == de_last);
  wire signed [ACC_W-1:0] step = (stg == 2'd0) ? W_S1 : (stg == 2'd1) ? W_S2 : W_S3;

  assign sw_ctrl = {ph == P_HOLD, ph == P_REST, (ph == P_DE) && dir,
                    (ph == P_DE) && !dir, (ph == P_INT) && zpass, (ph == P_INT) && !zpass};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= P_INT;
      stg    <= 2'd0;
      zpass  <= 1'b0;
      dir    <= 1'b0;
      rng_q  <= rng_hi;
      ph_cnt <= '0;
      cy_cnt <= '0;
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done   <= 1'b0;
      cy_cnt <= cyc_end ? '0 : cy_cnt + 1'b1;
      if (cyc_end) begin
        done   <= 1'b1;
        result <= RES_W'(acc / TEN);
        acc    <= '0;
        ph     <= P_INT;
        zpass  <= 1'b0;
        stg    <= 2'd0;
        ph_cnt <= '0;
        rng_q  <= rng_hi;
      end else begin
        case (ph)
          P_INT: begin
            if (ph_cnt == int_last) begin
              ph     <= P_DE;
              stg    <= 2'd0;
              dir    <= cmp_pos;
              ph_cnt <= '0;
            end else ph_cnt <= ph_cnt + 1'b1;
          end
          P_DE: begin
            acc <= (dir ^ zpass) ? acc + step : acc - step;
            if (de_stop) begin
              ph_cnt <= '0;
              if (stg != 2'd2) ph <= P_REST;
              else if (zpass)  ph <= P_HOLD;
              else begin
                ph    <= P_INT;
                zpass <= 1'b1;
              end
            end else ph_cnt <= ph_cnt + 1'b1;
          end
          P_REST: begin
            if (ph_cnt == PH_W'(REST_LEN - 1)) begin
              ph     <= P_DE;
              stg    <= stg + 2'd1;
              dir    <= cmp_pos;
              ph_cnt <= '0;
            end else ph_cnt <= ph_cnt + 1'b1;
          end
          P_HOLD: ;
          default: ph <= P_HOLD;
        endcase
      end
    end
  end
endmodule

// File: rtl/sint_adc_seq_chk.sv
module sint_adc_seq_chk #(
  parameter int INT_SHORT = 1000,
  parameter int INT_LONG  = 10000,
  parameter int CYCLE_LEN = 30000,
  parameter int RES_W     = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmp_pos,
  input logic [5:0]              sw_ctrl,
  input logic signed [RES_W-1:0] result,
  input logic                    done
);
  logic [31:0] int_run, gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_run <= '0;
      gap     <= '0;
    end else begin
      int_run <= sw_ctrl[0] ? int_run + 1 : '0;
      gap     <= done ? 32'd1 : gap + 1;
    end
  end

  AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sw_ctrl) == 1); // R2
  AST_INT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_ctrl[0]) |-> (int_run == INT_SHORT || int_run == INT_LONG)); // R3
  AST_DIR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ctrl[3]) |-> $past(cmp_pos)); // R4
  AST_DIR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ctrl[2]) |-> !$past(cmp_pos)); // R4
  AST_END_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ctrl[3] && !cmp_pos |=> !sw_ctrl[3]); // R5
  AST_END_UP: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ctrl[2] && cmp_pos |=> !sw_ctrl[2]); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_CYCLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> gap == CYCLE_LEN); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R10
endmodule

bind sint_adc_seq sint_adc_seq_chk #(
  .INT_SHORT(INT_SHORT), .INT_LONG(INT_LONG), .CYCLE_LEN(CYCLE_LEN), .RES_W(RES_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmp_pos(cmp_pos), .sw_ctrl(sw_ctrl),
  .result(result), .done(done)
);

// File: tb/sint_adc_seq_tb.sv
module sint_adc_seq_tb_top;
  localparam int NS = 20, NL = 200, D1 = 500, DF = 20, RL = 4, CL = 2000, RW = 20;
  localparam longint REF = 4000;
  // rng_hi, vin, voff, expected reading
  localparam longint TV [8][4] = '{
    '{1,  2470,    0,   123},
    '{1, -1550,  300,   -77},
    '{0,   913,  -50,   456},
    '{0,     1,    0,     0},
    '{0,    -1,   37,     0},
    '{1, 39990,    0,  1999},
    '{0,  6001,    0,  3000},
    '{0, -2469, -100, -1234}
  };

  logic clk = 0, rst_n = 0, rng_hi = 0, cmp_pos = 0;
  logic [5:0] sw;
  logic signed [RW-1:0] result;
  logic done;

  always #2 clk = ~clk;

  sint_adc_seq #(.INT_SHORT(NS), .INT_LONG(NL), .DE1_MAX(D1), .DE_FINE_MAX(DF),
                 .REST_LEN(RL), .CYCLE_LEN(CL), .RES_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rng_hi(rng_hi), .cmp_pos(cmp_pos),
    .sw_ctrl(sw), .result(result), .done(done));

  longint v = 0, vin = 0, voff = 0;
  int n_chk = 0, n_bad = 0;
  logic [5:0] prev_sw = 6'b000001;
  logic signed [RW-1:0] prev_res = '0;
  int run = 0, gap_cnt = 0, last_gap = 0;
  int cur_int = 0, cur_zint = 0, cur_de1 = 0, cur_rest = 0;
  int last_int = 0, last_zint = 0, last_de1 = 0, last_rest = 0;
  int dir_err = 0, hot_err = 0, hold_err = 0;

  // behavioural integrator and phase monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sw = sw; run = 0; v = 0; cmp_pos = 0; gap_cnt = 0; prev_res = result;
    end else begin
      if ($countones(sw) != 1) hot_err++;
      if (result != prev_res && !done) hold_err++;
      prev_res = result;
      if (done) begin
        last_int = cur_int; last_zint = cur_zint; last_de1 = cur_de1; last_rest = cur_rest;
        cur_int = 0; cur_zint = 0; cur_de1 = 0; cur_rest = 0;
        last_gap = gap_cnt; gap_cnt = 1;
      end else gap_cnt++;
      if (sw != prev_sw) begin
        if (prev_sw == 6'b000001) cur_int = run;
        if (prev_sw == 6'b000010) cur_zint = run;
        if ((prev_sw == 6'b000100 || prev_sw == 6'b001000) && cur_de1 == 0) cur_de1 = run;
        if (prev_sw == 6'b010000 && cur_rest == 0) cur_rest = run;
        if (sw == 6'b001000 && !cmp_pos) dir_err++;
        if (sw == 6'b000100 && cmp_pos) dir_err++;
        if (sw == 6'b000001 || sw == 6'b000010) v = 0;
        if (sw == 6'b010000) v = v * 10;
        run = 1;
      end else run++;
      case (sw)
        6'b000001: v = v + vin + voff;
        6'b000010: v = v + voff;
        6'b000100: v = v + REF;
        6'b001000: v = v - REF;
        default: ;
      endcase
      prev_sw = sw;
      cmp_pos = (v > 0);
    end
  end

  task automatic chk_eq(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    do @(negedge clk); while (done !== 1'b1);
    #1;
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_eq("R1 reset sw_ctrl", longint'(sw), 1);
    chk_eq("R1 reset result", longint'(result), 0);
    chk_eq("R1 reset done", longint'(done), 0);
    rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      rng_hi = TV[i][0][0]; vin = TV[i][1]; voff = TV[i][2];
      wait_done();
      wait_done();
      chk_eq("R7 R8 reading", longint'(result), TV[i][3]);
      chk_eq("R3 integrate length", last_int, TV[i][0] != 0 ? NS : NL);
      chk_eq("R8 zero integrate length", last_zint, last_int);
      chk_eq("R9 cycle length", last_gap, CL);
      chk_eq("R6 rest length", last_rest, RL);
      if (i == 0) begin
        @(negedge clk);
        chk_eq("R9 done one clock", longint'(done), 0);
      end
    end

    // range change in the middle of a long integrate
    repeat (100) @(negedge clk);
    rng_hi = 1;
    wait_done();
    chk_eq("R3 range held mid-cycle", last_int, NL);
    chk_eq("R3 zero pass range held", last_zint, NL);
    wait_done();
    chk_eq("R3 new range next cycle", last_int, NS);

    // overdriven input: every stage of the measurement pass times out
    vin = 200000; voff = 0;
    wait_done();
    wait_done();
    chk_eq("R5 stage one timeout", last_de1, D1);
    chk_eq("R5 R7 timeout reading", longint'(result), 5022);

    chk_eq("R4 direction from comparator", dir_err, 0);
    chk_eq("R2 one-hot switches", hot_err, 0);
    chk_eq("R10 result held between done", hold_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule